// File: doc/BRIEF.md
# Tri-Port Latched Bus Exchanger

This block moves words between one A port and two B ports, named 1B and 2B. All three ports have the same width, 12 bits by default. Each of the four transfer paths has its own storage element with its own latch enable: A to 1B, A to 2B, 1B to A and 2B to A. While an enable is high the path is transparent: its output follows its input in the same cycle. When the enable drops, the path holds the word it last captured.

The word driven toward A comes from a 2:1 select between the 1B-side and 2B-side paths. Each port has its own active-low output enable, so the two B ports can work independently. One can be read while the other is written, which suits memory interleaving and address multiplexing. The tri-state pins are split into separate input, output and drive-enable signals. The drive-enable is active high and shows whether the port would drive its pins.

Each storage element behaves as a transparent latch built from a clocked hold register. With the enable high, the output is the live input. With it low, the output is the input value sampled at the last rising clock edge where the enable was high. A synchronous active-low reset clears every hold register.

Top module: `bus_exchanger`

## Requirements
- R1: After a reset, with all four latch enables low, `a_out`, `b1_out` and `b2_out` are all zero.
- R2: While `le_a1b` is high, `b1_out` equals `a_in` in the same cycle.
- R3: After `le_a1b` falls, `b1_out` keeps the `a_in` value sampled at the last rising edge with `le_a1b` high, and later changes of `a_in` have no effect on it.
- R4: The A-to-2B path is transparent while `le_a2b` is high and holds after it falls, whatever `le_a1b` does.
- R5: With `sel_1b` = 1, `a_out` is the 1B-to-A path: it equals `b1_in` while `le_1ba` is high and holds after `le_1ba` falls.
- R6: With `sel_1b` = 0, `a_out` is the 2B-to-A path: it equals `b2_in` while `le_2ba` is high and holds after `le_2ba` falls.
- R7: Changing `sel_1b` switches `a_out` between the two held B-to-A words without disturbing either one.
- R8: `a_drv_en` is the inverse of `oe_a_n` and does not depend on any other enable.
- R9: `b1_drv_en` is the inverse of `oe_1b_n`, and `b2_drv_en` is the inverse of `oe_2b_n`. Each follows only its own enable.
- R10: With both `le_a1b` and `le_a2b` high, one A word reaches both B ports in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold registers |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 12 | Word arriving at port A |
| b1_in | input | 12 | Word arriving at port 1B |
| b2_in | input | 12 | Word arriving at port 2B |
| le_a1b | input | 1 | Latch enable, A to 1B |
| le_a2b | input | 1 | Latch enable, A to 2B |
| le_1ba | input | 1 | Latch enable, 1B to A |
| le_2ba | input | 1 | Latch enable, 2B to A |
| sel_1b | input | 1 | 1 picks the 1B-to-A path, 0 picks the 2B-to-A path |
| oe_a_n | input | 1 | Active-low output enable, port A |
| oe_1b_n | input | 1 | Active-low output enable, port 1B |
| oe_2b_n | input | 1 | Active-low output enable, port 2B |
| a_out | output | 12 | Word driven toward A |
| b1_out | output | 12 | Word driven toward 1B |
| b2_out | output | 12 | Word driven toward 2B |
| a_drv_en | output | 1 | Port A drives its pins |
| b1_drv_en | output | 1 | Port 1B drives its pins |
| b2_drv_en | output | 1 | Port 2B drives its pins |

## Verification
Each path is first driven with its enable held high and a changing input. This separates a true same-cycle pass-through from an output that lags by a register. The enable is then dropped while the input is changed at once, so a correct hold differs from one that keeps tracking or captures a late value. The B paths are driven with different words while only one enable toggles, and the select is flipped between two distinct held words, which exposes crossed paths or a swapped select polarity. The output enables are walked one at a time, so an enable wired to the wrong port shows up.

// File: rtl/exch_pkg.sv
// Shared width and word type for the bus exchanger.
// Assumes every port of the exchanger carries the same word width.
package exch_pkg;
    parameter int EXCH_W = 12;
    typedef logic [EXCH_W-1:0] exch_word_t;
endpackage

// File: rtl/exch_latch.sv
// Transparent latch stage built from a clocked hold register.
// With le high, q follows d combinationally. With le low, q is the d
// value sampled at the last rising edge where le was high.
// Assumes d is stable across the edge where le is last high.
module exch_latch #(
    parameter int W = exch_pkg::EXCH_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held_q;

    // Capture the open value on every edge with the latch open; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (le)
            held_q <= d;
    end

    // Pass d through while open, show the held word while closed.
    always_comb q = le ? d : held_q;
endmodule

// File: rtl/exch_sel.sv
// Two-way word select for the path toward port A.
// Assumes pick_first = 1 chooses in_first.
module exch_sel #(
    parameter int W = exch_pkg::EXCH_W
) (
    input  logic         pick_first,
    input  logic [W-1:0] in_first,
    input  logic [W-1:0] in_second,
    output logic [W-1:0] y
);
    // Steer the chosen word to the output.
    always_comb y = pick_first ? in_first : in_second;
endmodule

// File: rtl/exch_oe.sv
// Converts a group of active-low output enables to active-high drive flags.
// Assumes one bit per port, same bit order in and out.
module exch_oe #(
    parameter int N = 3
) (
    input  logic [N-1:0] oe_n,
    output logic [N-1:0] drv_en
);
    for (genvar i = 0; i < N; i++) begin : g_oe
        // Invert each port's enable on its own.
        assign drv_en[i] = ~oe_n[i];
    end
endmodule

// File: rtl/bus_exchanger.sv
// Three-port latched bus exchanger.
// Four latch stages (A->1B, A->2B, 1B->A, 2B->A), a select on the path
// back to A, and per-port active-low output enables.
// Assumes tri-state pins are split into in / out / drive-enable outside.
module bus_exchanger #(
    parameter int W = exch_pkg::EXCH_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b1_in,
    input  logic [W-1:0] b2_in,
    input  logic         le_a1b,
    input  logic         le_a2b,
    input  logic         le_1ba,
    input  logic         le_2ba,
    input  logic         sel_1b,
    input  logic         oe_a_n,
    input  logic         oe_1b_n,
    input  logic         oe_2b_n,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b1_out,
    output logic [W-1:0] b2_out,
    output logic         a_drv_en,
    output logic         b1_drv_en,
    output logic         b2_drv_en
);
    localparam int NPORT = 3;

    logic [W-1:0] q_1ba, q_2ba;
    logic [NPORT-1:0] drv_vec;

    // Outbound stage toward port 1B.
    exch_latch #(.W(W)) u_lat_a1b (
        .clk(clk), .rst_n(rst_n), .le(le_a1b), .d(a_in), .q(b1_out)
    );

    // Outbound stage toward port 2B.
    exch_latch #(.W(W)) u_lat_a2b (
        .clk(clk), .rst_n(rst_n), .le(le_a2b), .d(a_in), .q(b2_out)
    );

    // Inbound stage from port 1B.
    exch_latch #(.W(W)) u_lat_1ba (
        .clk(clk), .rst_n(rst_n), .le(le_1ba), .d(b1_in), .q(q_1ba)
    );

    // Inbound stage from port 2B.
    exch_latch #(.W(W)) u_lat_2ba (
        .clk(clk), .rst_n(rst_n), .le(le_2ba), .d(b2_in), .q(q_2ba)
    );

    // Select which inbound word drives port A.
    exch_sel #(.W(W)) u_sel (
        .pick_first(sel_1b), .in_first(q_1ba), .in_second(q_2ba), .y(a_out)
    );

    // Per-port drive flags; bit 0 = A, bit 1 = 1B, bit 2 = 2B.
    exch_oe #(.N(NPORT)) u_oe (
        .oe_n({oe_2b_n, oe_1b_n, oe_a_n}), .drv_en(drv_vec)
    );

    assign a_drv_en  = drv_vec[0];
    assign b1_drv_en = drv_vec[1];
    assign b2_drv_en = drv_vec[2];
endmodule

// File: rtl/bus_exchanger_chk.sv
// Port-level checker for bus_exchanger, bound to every instance.
// Assumes the same port names and width as the top module.
module bus_exchanger_chk #(
    parameter int W = exch_pkg::EXCH_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b1_in,
    input logic [W-1:0] b2_in,
    input logic         le_a1b,
    input logic         le_a2b,
    input logic         le_1ba,
    input logic         le_2ba,
    input logic         sel_1b,
    input logic         oe_a_n,
    input logic         oe_1b_n,
    input logic         oe_2b_n,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b1_out,
    input logic [W-1:0] b2_out,
    input logic         a_drv_en,
    input logic         b1_drv_en,
    input logic         b2_drv_en
);
    assert_pass_a1b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        le_a1b |-> b1_out == a_in);

    assert_hold_a1b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_a1b && $past(!le_a1b) && $past(rst_n)) |-> $stable(b1_out));

    assert_pass_a2b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        le_a2b |-> b2_out == a_in);

    assert_hold_a2b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_a2b && $past(!le_a2b) && $past(rst_n)) |-> $stable(b2_out));

    assert_sel_1b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_1b && le_1ba) |-> a_out == b1_in);

    assert_sel_2b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_1b && le_2ba) |-> a_out == b2_in);

    assert_oe_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        a_drv_en != oe_a_n);

    assert_oe_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (b1_drv_en != oe_1b_n) && (b2_drv_en != oe_2b_n));
endmodule

bind bus_exchanger bus_exchanger_chk #(.W(W)) chk_i (.*);

// File: tb/bus_exchanger_tb_top.sv
// Directed bench for bus_exchanger: one task per scenario.
module bus_exchanger_tb_top;
    localparam int W = 12;
    localparam time TCK = 20ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         le_a1b = 0, le_a2b = 0, le_1ba = 0, le_2ba = 0, sel_1b = 0;
    logic         oe_a_n = 1, oe_1b_n = 1, oe_2b_n = 1;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_drv_en, b1_drv_en, b2_drv_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(TCK/2) clk = ~clk;

    bus_exchanger #(.W(W)) dut_i (.*);

    // Compare one value and log a failure.
    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Wait for the next falling edge, then settle.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        check("R1 a_out", a_out, '0);
        check("R1 b1_out", b1_out, '0);
        check("R1 b2_out", b2_out, '0);
    endtask

    task automatic t_a1b();
        a_in = 12'h3A5; le_a1b = 1; #1;
        check("R2 pass", b1_out, 12'h3A5);
        a_in = 12'h0F1; #1;
        check("R2 follow", b1_out, 12'h0F1);
        step();
        le_a1b = 0; a_in = 12'hBEE; #1;
        check("R3 hold", b1_out, 12'h0F1);
        step();
        a_in = 12'h123; #1;
        check("R3 ignore a_in", b1_out, 12'h0F1);
    endtask

    task automatic t_a2b();
        a_in = 12'h5C3; le_a2b = 1; #1;
        check("R4 pass", b2_out, 12'h5C3);
        step();
        le_a2b = 0; a_in = 12'h777; le_a1b = 1; #1;
        check("R4 hold", b2_out, 12'h5C3);
        check("R4 b1 tracks", b1_out, 12'h777);
        step();
        le_a1b = 0; #1;
        check("R4 still held", b2_out, 12'h5C3);
    endtask

    task automatic t_b_to_a();
        sel_1b = 1; b1_in = 12'h1A1; le_1ba = 1; #1;
        check("R5 pass", a_out, 12'h1A1);
        step();
        le_1ba = 0; b1_in = 12'hFFF; #1;
        check("R5 hold", a_out, 12'h1A1);
        sel_1b = 0; b2_in = 12'h2B2; le_2ba = 1; #1;
        check("R6 pass", a_out, 12'h2B2);
        step();
        le_2ba = 0; b2_in = 12'h000; #1;
        check("R6 hold", a_out, 12'h2B2);
        sel_1b = 1; #1;
        check("R7 back to 1B", a_out, 12'h1A1);
        sel_1b = 0; #1;
        check("R7 back to 2B", a_out, 12'h2B2);
    endtask

    task automatic t_oe();
        oe_a_n = 0; #1;
        check("R8 a on", {11'b0, a_drv_en}, 12'h1);
        check("R9 b1 off", {11'b0, b1_drv_en}, 12'h0);
        check("R9 b2 off", {11'b0, b2_drv_en}, 12'h0);
        oe_a_n = 1; oe_1b_n = 0; #1;
        check("R8 a off", {11'b0, a_drv_en}, 12'h0);
        check("R9 b1 on", {11'b0, b1_drv_en}, 12'h1);
        check("R9 b2 still off", {11'b0, b2_drv_en}, 12'h0);
        oe_1b_n = 1; oe_2b_n = 0; #1;
        check("R9 b2 on", {11'b0, b2_drv_en}, 12'h1);
        check("R9 b1 off again", {11'b0, b1_drv_en}, 12'h0);
        oe_2b_n = 1;
        step();
    endtask

    task automatic t_both();
        a_in = 12'hACE; le_a1b = 1; le_a2b = 1; #1;
        check("R10 b1", b1_out, 12'hACE);
        check("R10 b2", b2_out, 12'hACE);
        step();
        le_a1b = 0; le_a2b = 0; a_in = 12'h000; #1;
        check("R10 b1 held", b1_out, 12'hACE);
        check("R10 b2 held", b2_out, 12'hACE);
    endtask

    initial begin
        step();
        t_reset();
        t_a1b();
        t_a2b();
        t_b_to_a();
        t_oe();
        t_both();
        step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule